// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

A clocked state machine that performs one read or one write at a time on an external 8192 x 8 asynchronous static RAM. On the system side a request carries a 13-bit address, a write flag and 8 bits of write data. The request is taken only while `ready` is high. Read results come back on `rdData` with a one-clock `rdValid` pulse.

On the memory side the controller drives a low-true select, a high-true select, a low-true output enable, a low-true write strobe and the address. The data bus is split into an outgoing byte with its own driver enable and an incoming byte. Every phase of a cycle lasts a whole number of clocks. Each count is the nanosecond minimum divided by `CLK_PERIOD_NS`, rounded up, and is never less than one clock. The counts include a gap after each read, so the memory stops driving the bus before the controller turns on its own drivers.

With the default 10 ns clock the phases are as follows:
- A read holds output enable low for 6 clocks, then leaves a 2-clock turnaround.
- A write has 1 setup clock, a 4-clock write strobe and 1 hold clock.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Out of reset, `ready` is 1, `memCe1N` is 1, `memCe2` is 0, `memOeN` is 1, `memWeN` is 1, `memDqOe` is 0 and `rdValid` is 0.
- R2: A request is accepted only on a rising clock edge where `reqValid` and `ready` are both 1. From that edge `ready` stays 0 until the cycle ends, and `memAddr` holds the accepted address. A request raised and withdrawn while `ready` is 0 has no effect.
- R3: A read (`reqWrite` = 0) selects the device, keeps `memWeN` at 1 and holds `memOeN` at 0 for RD = max(ceil(55/T), ceil(25/T)) clocks, where T is `CLK_PERIOD_NS`. `memDqIn` is captured on the last of those clocks and shows on `rdData` with a one-clock `rdValid` pulse in the next clock.
- R4: After a read, select and output enable stay inactive for TURN = ceil(20/T) clocks before `ready` returns to 1. `memDqOe` never rises within 20 ns of the memory's output enable being released.
- R5: A write (`reqWrite` = 1) selects the device and drives `memDqOut` with `memDqOe` = 1 for PULSE + 2 clocks. Those clocks are one setup clock with `memWeN` = 1, PULSE clocks with `memWeN` = 0, and one hold clock with `memWeN` = 1. PULSE = max(ceil(25/T), ceil(40/T), ceil(50/T) - 2), never below 1.
- R6: `memOeN` is 1 in every clock where `memWeN` is 0 or `memDqOe` is 1.
- R7: Whenever `ready` is 1, the device is deselected (`memCe1N` = 1, `memCe2` = 0).
- R8: `ready` stays 0 for exactly RD + TURN clocks after a read is accepted, and for exactly PULSE + 2 clocks after a write is accepted.
- R9: Data written to an address is returned by later reads of that address until it is overwritten. This includes the lowest address 0 and the highest address 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, low-true |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Request address |
| reqWdata | input | 8 | Write data |
| ready | output | 1 | Idle, can take a request |
| rdData | output | 8 | Captured read data |
| rdValid | output | 1 | One-clock pulse, rdData is new |
| memCe1N | output | 1 | Memory select, low-true |
| memCe2 | output | 1 | Memory select, high-true |
| memOeN | output | 1 | Memory output enable, low-true |
| memWeN | output | 1 | Memory write strobe, low-true |
| memAddr | output | 13 | Memory address |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqOe | output | 1 | Driver enable for memDqOut |
| memDqIn | input | 8 | Data returned by the memory |

## Verification
The in-RTL properties check the following on every clock:
- output enable stays high whenever the write strobe or the controller's drivers are active;
- the write strobe low time reaches PULSE;
- at least TURN clocks of released output enable precede any rise of the driver enable;
- the address is steady while the device stays selected;
- `rdValid` follows a clock with output enable low.

Other behaviour only the bench's scenarios can show. The bench's memory model corrupts stored data when an access breaks an access-time, setup or pulse-width minimum, and it records bus contention. Against that model the scenarios show:
- the data returned by reads;
- the exact busy lengths;
- that requests withdrawn while busy are ignored;
- contention-free read-to-write turnaround.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD
  } ctlState_e;

  // registered memory-side controls, decoded from the next state
  typedef struct packed {
    logic busy;
    logic chipSel;
    logic outEn;
    logic wrStrobe;
    logic drvEn;
  } pinCtl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
  } ctlStrobe_t;

  function automatic int cyclesFor(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_DOE_NS      = 25,
  parameter int T_HZOE_NS     = 20,
  parameter int T_WC_NS       = 50,
  parameter int T_PWE_NS      = 25,
  parameter int T_AW_NS       = 40,
  parameter int T_SD_NS       = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output ctlStrobe_t strobe,
  output pinCtl_t    pins
);

  localparam int RD_CYC = maxOf(cyclesFor(T_RC_NS, CLK_PERIOD_NS),
                          maxOf(cyclesFor(T_AA_NS, CLK_PERIOD_NS),
                                cyclesFor(T_DOE_NS, CLK_PERIOD_NS)));
  localparam int TURN_CYC = cyclesFor(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int WPULSE_CYC = maxOf(1,
                              maxOf(cyclesFor(T_WC_NS, CLK_PERIOD_NS) - 2,
                              maxOf(cyclesFor(T_PWE_NS, CLK_PERIOD_NS),
                              maxOf(cyclesFor(T_AW_NS, CLK_PERIOD_NS),
                                    cyclesFor(T_SD_NS, CLK_PERIOD_NS)))));
  localparam int CNT_MAX = maxOf(RD_CYC, maxOf(TURN_CYC, WPULSE_CYC));
  localparam int CNT_W   = maxOf(1, $clog2(CNT_MAX + 1));

  ctlState_e  state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  pinCtl_t    pinsQ;
  logic       accept;
  logic       cntDone;

  assign accept  = reqValid && (state == ST_IDLE);
  assign cntDone = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqWrite) begin
            stateNext = ST_WSET;
            cntNext   = '0;
          end else begin
            stateNext = ST_RD;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (cntDone) begin
          stateNext = ST_TURN;
          cntNext   = CNT_W'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntDone) stateNext = ST_IDLE;
        else         cntNext   = cnt - 1'b1;
      end
      ST_WSET: begin
        stateNext = ST_WPULSE;
        cntNext   = CNT_W'(WPULSE_CYC - 1);
      end
      ST_WPULSE: begin
        if (cntDone) stateNext = ST_WHOLD;
        else         cntNext   = cnt - 1'b1;
      end
      ST_WHOLD: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  function automatic pinCtl_t decodePins(input ctlState_e s);
    pinCtl_t p;
    p = '0;
    case (s)
      ST_IDLE:   p = '0;
      ST_RD:     begin p.busy = 1'b1; p.chipSel = 1'b1; p.outEn = 1'b1; end
      ST_TURN:   p.busy = 1'b1;
      ST_WSET:   begin p.busy = 1'b1; p.chipSel = 1'b1; p.drvEn = 1'b1; end
      ST_WPULSE: begin p.busy = 1'b1; p.chipSel = 1'b1; p.drvEn = 1'b1; p.wrStrobe = 1'b1; end
      ST_WHOLD:  begin p.busy = 1'b1; p.chipSel = 1'b1; p.drvEn = 1'b1; end
      default:   p = '0;
    endcase
    return p;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pinsQ <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      pinsQ <= decodePins(stateNext);
    end
  end

  assign pins           = pinsQ;
  assign strobe.load    = accept;
  assign strobe.capture = (state == ST_RD) && cntDone;

  // checker counters
  logic [7:0] weLowCnt;
  logic [7:0] oeHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowCnt  <= '0;
      oeHighCnt <= 8'hFF;
    end else begin
      if (!pinsQ.wrStrobe)      weLowCnt <= '0;
      else if (weLowCnt != 8'hFF) weLowCnt <= weLowCnt + 1'b1;
      if (pinsQ.outEn)           oeHighCnt <= '0;
      else if (oeHighCnt != 8'hFF) oeHighCnt <= oeHighCnt + 1'b1;
    end
  end

  // R6
  oe_vs_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinsQ.wrStrobe |-> !pinsQ.outEn);

  // R6
  oe_vs_drv_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinsQ.drvEn |-> !pinsQ.outEn);

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinsQ.wrStrobe) |-> (weLowCnt >= 8'(WPULSE_CYC)));

  // R4
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsQ.drvEn) |-> (oeHighCnt >= 8'(TURN_CYC)));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  pinCtl_t           pins,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.capture;
      if (strobe.capture) rdDataQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign rdData   = rdDataQ;
  assign rdValid  = rdValidQ;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pins.chipSel && $past(pins.chipSel)) |-> $stable(addrQ));

  // R3
  rdvalid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValidQ |-> $past(pins.outEn));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  ctlStrobe_t strobe;
  pinCtl_t    pins;

  sram_ctl_fsm #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .strobe   (strobe),
    .pins     (pins)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pins     (pins),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign ready   = !pins.busy;
  assign memCe1N = !pins.chipSel;
  assign memCe2  = pins.chipSel;
  assign memOeN  = !pins.outEn;
  assign memWeN  = !pins.wrStrobe;
  assign memDqOe = pins.drvEn;

endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  function automatic int ceilCyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD    = 6;
  localparam int EXP_TURN  = 2;
  localparam int EXP_PULSE = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [12:0] memAddr;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'h5A;

  int nChecks = 0;
  int nErrors = 0;
  int timingViol = 0;
  int contention = 0;
  int expRd, expTurn, expPulse;

  always #(HALF) clk = ~clk;

  sram_cycle_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .rdData(rdData),
    .rdValid(rdValid), .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory model ----------------
  logic [7:0] memArr [0:8191];
  logic [7:0] shadow [0:8191];
  logic selected, wrActive, memDriving;
  time readStart = 0, weFall = 0, dataChange = 0, addrChange = 0, driveOff = 0;

  assign selected   = !memCe1N && memCe2;
  assign wrActive   = selected && !memWeN;
  assign memDriving = selected && !memOeN && memWeN;

  always @(memCe1N or memCe2 or memOeN or memWeN or memAddr) readStart = $time;
  always @(posedge wrActive) weFall = $time;
  always @(memDqOut or posedge memDqOe) dataChange = $time;
  always @(memAddr) addrChange = $time;
  always @(negedge memDriving) driveOff = $time;

  always @(negedge wrActive) begin
    if (($time - weFall >= 25) && ($time - dataChange >= 25) &&
        ($time - addrChange >= 40) && memDqOe)
      memArr[memAddr] = memDqOut;
    else begin
      memArr[memAddr] = ~memDqOut;
      timingViol++;
    end
  end

  always @(posedge memDqOe) begin
    if (memDriving || ($time - driveOff < 20)) contention++;
  end

  always @(negedge clk) begin
    if (memDriving && ($time + HALF - readStart >= 55) && ($time + HALF - readStart >= 25))
      memDqIn <= memArr[memAddr];
    else
      memDqIn <= 8'h5A ^ memAddr[7:0];
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // runs one access; noise raises and withdraws a foreign request while busy
  task automatic runOp(input bit wr, input logic [12:0] a, input logic [7:0] d,
                       input bit noise);
    int busy = 0, oeLow = 0, weLow = 0, drv = 0, turn = 0, vAt = -1, vCnt = 0;
    bit addrOk = 1, r6Ok = 1;
    logic [7:0] got = '0;
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    while (!ready) begin
      busy++;
      if (noise) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a ^ 13'h1; reqWdata = ~d;
      end
      if (selected && memAddr != a) addrOk = 0;
      if (!memOeN) oeLow++;
      if (!memWeN) weLow++;
      if (memDqOe) drv++;
      if (!selected && memOeN) turn++;
      if ((!memWeN || memDqOe) && !memOeN) r6Ok = 0;
      if (rdValid) begin vCnt++; vAt = busy; got = rdData; end
      @(negedge clk);
      reqValid = 1'b0;
    end
    check(addrOk, "R2", "address held during cycle", 0, 0);
    check(r6Ok, "R6", "output enable high during write/drive", 0, 0);
    check(!selected, "R7", "deselected when ready", int'(selected), 0);
    if (wr) begin
      shadow[a] = d;
      check(busy == expPulse + 2, "R8", "write busy clocks", busy, expPulse + 2);
      check(weLow == expPulse, "R5", "write strobe clocks", weLow, expPulse);
      check(drv == expPulse + 2, "R5", "driver enable clocks", drv, expPulse + 2);
      check(vCnt == 0, "R3", "no rdValid on write", vCnt, 0);
    end else begin
      check(busy == expRd + expTurn, "R8", "read busy clocks", busy, expRd + expTurn);
      check(oeLow == expRd, "R3", "output enable clocks", oeLow, expRd);
      check(turn == expTurn, "R4", "turnaround clocks", turn, expTurn);
      check(vCnt == 1 && vAt == expRd + 1, "R3", "rdValid position", vAt, expRd + 1);
      check(got == shadow[a], "R9", "read data", int'(got), int'(shadow[a]));
    end
  endtask

  initial begin
    expRd    = mx(ceilCyc(55), ceilCyc(25));
    expTurn  = ceilCyc(20);
    expPulse = mx(1, mx(ceilCyc(50) - 2, mx(ceilCyc(25), ceilCyc(40))));
    for (int i = 0; i < 8192; i++) begin
      memArr[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    // R1 reset values
    check(ready && memCe1N && !memCe2 && memOeN && memWeN && !memDqOe && !rdValid,
          "R1", "reset outputs",
          {ready, memCe1N, memCe2, memOeN, memWeN, memDqOe, rdValid}, 7'b1101100);
    rstN = 1'b1;
    @(negedge clk);
    check(expRd == EXP_RD && expPulse == EXP_PULSE && expTurn == EXP_TURN,
          "R3", "derived phase counts", expRd, EXP_RD);
    // directed: boundary addresses, read-to-write turnaround
    runOp(1'b1, 13'h0000, 8'hA1, 1'b0);
    runOp(1'b1, 13'h1FFF, 8'h3C, 1'b0);
    runOp(1'b0, 13'h0000, 8'h00, 1'b0);
    runOp(1'b0, 13'h1FFF, 8'h00, 1'b0);
    runOp(1'b1, 13'h1FFF, 8'hC3, 1'b0);
    runOp(1'b0, 13'h1FFF, 8'h00, 1'b0);
    // R2: noise requests while busy must not write a+1
    runOp(1'b1, 13'h0040, 8'h77, 1'b1);
    runOp(1'b0, 13'h0041, 8'h00, 1'b1);
    runOp(1'b0, 13'h0041, 8'h00, 1'b0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [12:0] ra;
      ra = 13'($urandom % 32);
      if ($urandom % 8 == 0) ra = 13'($urandom);
      runOp(1'($urandom), ra, 8'($urandom), 1'($urandom % 4 == 0));
    end
    repeat (3) @(negedge clk);
    check(contention == 0, "R4", "bus contention events", contention, 0);
    check(timingViol == 0, "R5", "write timing violations", timingViol, 0);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule